// File: doc/BRIEF.md
# Flat Panel Line and Frame Timing Generator

This block produces the raster timing for a flat panel from a dot-rate clock. A dot counter steps through each line: first a display window of character groups, then a fixed horizontal blanking tail. A line counter steps through the lines of a frame. From these two counters the block derives four signals. The shift clock enable gates the panel data clock. A one-dot line latch pulse ends each line. A first-line marker follows the incoming vertical sync. An AC-drive polarity signal reverses after a programmable number of lines. A fifth output, a slow cursor-blink phase, toggles after a fixed number of frames.

The geometry is programmed through plain configuration inputs. These cover the horizontal size in character groups, the vertical size, and the panel organisation. The panel can be single, dual with one data port, or dual with two data ports; the organisation sets the group width and the line count. A latch offset of up to 31 dots moves both edges of the display window and the latch pulse later. A rising edge on the sync input restarts the frame at dot 0 of line 0. A standby control silences every output and holds the counters until it is released.

Top module: `panel_timing_gen`

## Requirements
- R1: A character group is 8 dots wide for screen type codes 0 and 1 and 3, and 4 dots wide for code 2. When continuous mode is off, the shift clock enable is high for exactly (hsize+1) group widths in each line.
- R2: A line lasts the active dot count plus HBLANK_DOTS dots (default 40). Exactly one line latch pulse, one dot long, occurs in each line.
- R3: With a latch offset A, the shift clock enable starts at dot A of the line. The latch pulse sits at dot (active dots + A). Both edges move together by A.
- R4: When continuous mode is on, the shift clock enable is high on every dot of the line.
- R5: When the FLM delay control is 0, the first-line marker equals the sync input in the same cycle. When it is 1, the marker follows the sync input two clock cycles later.
- R6: The AC polarity signal toggles after every P+1 line latch pulses, where P is the 10-bit period value. P = 0 toggles it on every line.
- R7: A free-running frame has vsize+1 lines for screen type codes 0, 2 and 3, and vsize+2 lines for code 1.
- R8: The blink phase toggles once every 16 frames when the slow-blink control is 0, and once every 32 frames when it is 1. Frame starts are counted both from wrap and from sync.
- R9: A rising edge on the sync input sets the dot and line counters to zero at the next clock edge. The display window is then timed from that point.
- R10: While standby is high, all five outputs are low and the counters are held at zero. When standby is released, the line restarts at dot 0.
- R11: After reset the polarity and blink outputs are low, no latch pulse is present, and counting starts from dot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync_in | input | 1 | Frame sync; a rising edge restarts the frame |
| cfg_hsize | input | HSZ_W (8) | Character groups per line minus one |
| cfg_vsize | input | VSZ_W (9) | Vertical size code |
| cfg_scr_type | input | 2 | Screen organisation: 0 single, 1 dual one port, 2 dual two ports |
| cfg_latch_adj | input | LADJ_W (5) | Latch offset in dots |
| cfg_flm_delay | input | 1 | Delays the first-line marker by 2 cycles when set |
| cfg_sclk_always | input | 1 | Continuous shift clock enable when set |
| cfg_m_period | input | MPER_W (10) | AC polarity period, in lines, minus one |
| cfg_blink_slow | input | 1 | Selects a 32-frame blink instead of a 16-frame blink |
| cfg_standby | input | 1 | Stops all timing outputs when set |
| shclk_en | output | 1 | Shift clock enable |
| line_latch | output | 1 | One-dot line latch pulse |
| flm | output | 1 | First-line marker |
| m_pol | output | 1 | AC drive polarity |
| blink | output | 1 | Cursor blink phase |

## Verification
Shift clock enable and line latch are decoded combinationally from the dot counter. After the clock edge that registers a sync rise, the next falling-edge sample therefore shows dot 0. The latch appears act+A samples later. The first-line marker is due in the sync sample itself, or two samples later with the delay set. Polarity and blink change on the edge that follows the latch or frame-wrap cycle, so the bench measures them as counts of latches or cycles between two consecutive changes. The first, partial interval after a reconfiguration is always discarded. All outputs are sampled on the falling edge, and inputs are driven 1 ns after the rising edge, so every sample sees settled values.

// File: rtl/pt_pkg.sv
package pt_pkg;

  typedef enum logic [1:0] {
    SCR_SINGLE  = 2'd0,
    SCR_DUAL_1P = 2'd1,
    SCR_DUAL_2P = 2'd2,
    SCR_SPARE   = 2'd3
  } scr_type_e;

  // dots in one character group for a screen organisation
  function automatic int grp_dots(input logic [1:0] scr);
    return (scr_type_e'(scr) == SCR_DUAL_2P) ? 4 : 8;
  endfunction

  // dots in the display window of a line
  function automatic int active_dots(input int hsize, input logic [1:0] scr);
    return (hsize + 1) * grp_dots(scr);
  endfunction

  // scan lines in one frame
  function automatic int frame_lines(input int vsize, input logic [1:0] scr);
    return (scr_type_e'(scr) == SCR_DUAL_1P) ? vsize + 2 : vsize + 1;
  endfunction

endpackage

// File: rtl/pt_hcount.sv
module pt_hcount #(
  parameter int DPOS_W = 12,
  parameter int LADJ_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [DPOS_W-1:0] act_len,
  input  logic [DPOS_W-1:0] line_len,
  input  logic [LADJ_W-1:0] adj,
  input  logic              sclk_always,
  output logic [DPOS_W-1:0] dpos,
  output logic              shclk_en,
  output logic              latch,
  output logic              line_end
);
  logic [DPOS_W-1:0] win_lo;
  logic [DPOS_W-1:0] win_hi;
  logic              in_window;

  assign win_lo    = DPOS_W'(adj);
  assign win_hi    = act_len + win_lo;
  assign in_window = (dpos >= win_lo) && (dpos < win_hi);
  assign line_end  = run && (dpos >= line_len - 1'b1);
  assign shclk_en  = run && (sclk_always || in_window);
  assign latch     = run && (dpos == win_hi);

  always_ff @(posedge clk) begin
    if (!rst_n)                   dpos <= '0;
    else if (!run || restart)     dpos <= '0;
    else if (line_end)            dpos <= '0;
    else                          dpos <= dpos + 1'b1;
  end
endmodule

// File: rtl/pt_vcount.sv
module pt_vcount #(
  parameter int LCNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic              step,
  input  logic [LCNT_W-1:0] frame_lines,
  output logic              frame_wrap
);
  logic [LCNT_W-1:0] lcnt;

  assign frame_wrap = run && step && (lcnt >= frame_lines - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)               lcnt <= '0;
    else if (!run || restart) lcnt <= '0;
    else if (frame_wrap)      lcnt <= '0;
    else if (step)            lcnt <= lcnt + 1'b1;
  end
endmodule

// File: rtl/pt_toggle_div.sv
module pt_toggle_div #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [CW-1:0] limit,
  output logic          tog
);
  logic [CW-1:0] cnt;
  logic          reload;

  assign reload = step && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      tog <= 1'b0;
    end else if (reload) begin
      cnt <= '0;
      tog <= ~tog;
    end else if (step) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen #(
  parameter int HSZ_W       = 8,
  parameter int VSZ_W       = 9,
  parameter int LADJ_W      = 5,
  parameter int MPER_W      = 10,
  parameter int HBLANK_DOTS = 40,
  parameter int BLINK_FAST  = 16,
  parameter int BLINK_SLOW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_in,
  input  logic [HSZ_W-1:0]  cfg_hsize,
  input  logic [VSZ_W-1:0]  cfg_vsize,
  input  logic [1:0]        cfg_scr_type,
  input  logic [LADJ_W-1:0] cfg_latch_adj,
  input  logic              cfg_flm_delay,
  input  logic              cfg_sclk_always,
  input  logic [MPER_W-1:0] cfg_m_period,
  input  logic              cfg_blink_slow,
  input  logic              cfg_standby,
  output logic              shclk_en,
  output logic              line_latch,
  output logic              flm,
  output logic              m_pol,
  output logic              blink
);
  localparam int MAX_LINE = (2 ** HSZ_W) * 8 + HBLANK_DOTS + (2 ** LADJ_W);
  localparam int DPOS_W   = $clog2(MAX_LINE + 1);
  localparam int LCNT_W   = VSZ_W + 1;
  localparam int BLK_W    = $clog2(BLINK_SLOW);

  logic              run;
  logic              vs_d1, vs_d2;
  logic              vs_rise;
  logic [DPOS_W-1:0] act_len, line_len, dpos;
  logic [LCNT_W-1:0] frame_len;
  logic              line_end, frame_wrap, frame_tick;
  logic              m_state, blink_state;
  logic [BLK_W-1:0]  blink_limit;

  assign run       = ~cfg_standby;
  assign vs_rise   = vsync_in & ~vs_d1;
  assign act_len   = DPOS_W'(pt_pkg::active_dots(int'(cfg_hsize), cfg_scr_type));
  assign line_len  = act_len + DPOS_W'(HBLANK_DOTS);
  assign frame_len = LCNT_W'(pt_pkg::frame_lines(int'(cfg_vsize), cfg_scr_type));
  assign frame_tick = frame_wrap | (vs_rise & run);
  assign blink_limit = cfg_blink_slow ? BLK_W'(BLINK_SLOW - 1) : BLK_W'(BLINK_FAST - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_d1 <= 1'b0;
      vs_d2 <= 1'b0;
    end else begin
      vs_d1 <= vsync_in;
      vs_d2 <= vs_d1;
    end
  end

  pt_hcount #(.DPOS_W(DPOS_W), .LADJ_W(LADJ_W)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(vs_rise),
    .act_len(act_len), .line_len(line_len), .adj(cfg_latch_adj),
    .sclk_always(cfg_sclk_always), .dpos(dpos), .shclk_en(shclk_en),
    .latch(line_latch), .line_end(line_end)
  );

  pt_vcount #(.LCNT_W(LCNT_W)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(vs_rise),
    .step(line_end), .frame_lines(frame_len), .frame_wrap(frame_wrap)
  );

  pt_toggle_div #(.CW(MPER_W)) u_mdiv (
    .clk(clk), .rst_n(rst_n), .step(line_latch),
    .limit(cfg_m_period), .tog(m_state)
  );

  pt_toggle_div #(.CW(BLK_W)) u_bdiv (
    .clk(clk), .rst_n(rst_n), .step(frame_tick),
    .limit(blink_limit), .tog(blink_state)
  );

  assign flm   = run & (cfg_flm_delay ? vs_d2 : vsync_in);
  assign m_pol = run & m_state;
  assign blink = run & blink_state;
endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
  parameter int DPOS_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vsync_in,
  input logic              standby,
  input logic              flm_delay,
  input logic              line_latch,
  input logic              flm,
  input logic              vs_rise,
  input logic              frame_tick,
  input logic              m_state,
  input logic              blink_state,
  input logic [DPOS_W-1:0] dpos
);
  AST_LATCH_SINGLE_DOT: assert property (@(posedge clk) disable iff (!rst_n)
    line_latch |=> !line_latch); // R2

  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_rise && !standby) |=> (dpos == '0)); // R9

  AST_FLM_TWO_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (flm_delay && !standby && $past(vsync_in, 2)) |-> flm); // R5

  AST_M_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(m_state) |-> $past(line_latch)); // R6

  AST_BLINK_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(blink_state) |-> $past(frame_tick)); // R8

  AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && $past(standby)) |-> (dpos == '0) && !line_latch && !flm); // R10
endmodule

bind panel_timing_gen pt_checker #(.DPOS_W(DPOS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .standby(cfg_standby),
  .flm_delay(cfg_flm_delay), .line_latch(line_latch), .flm(flm),
  .vs_rise(vs_rise), .frame_tick(frame_tick), .m_state(m_state),
  .blink_state(blink_state), .dpos(dpos)
);

// File: tb/sim_panel_timing_gen.sv
module sim_panel_timing_gen;
  localparam int HB = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vsync_in = 1'b0;
  logic [7:0] cfg_hsize = 8'd0;
  logic [8:0] cfg_vsize = 9'd1;
  logic [1:0] cfg_scr_type = 2'd0;
  logic [4:0] cfg_latch_adj = 5'd0;
  logic       cfg_flm_delay = 1'b0;
  logic       cfg_sclk_always = 1'b0;
  logic [9:0] cfg_m_period = 10'd0;
  logic       cfg_blink_slow = 1'b0;
  logic       cfg_standby = 1'b0;
  logic       shclk_en, line_latch, flm, m_pol, blink;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int first_sh; int sh_cnt; int latch_pos; int line_len; int flm_at;
  } line_exp_t;
  line_exp_t sb_q[$];

  always #4 clk = ~clk;

  panel_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .cfg_hsize(cfg_hsize),
    .cfg_vsize(cfg_vsize), .cfg_scr_type(cfg_scr_type), .cfg_latch_adj(cfg_latch_adj),
    .cfg_flm_delay(cfg_flm_delay), .cfg_sclk_always(cfg_sclk_always),
    .cfg_m_period(cfg_m_period), .cfg_blink_slow(cfg_blink_slow),
    .cfg_standby(cfg_standby), .shclk_en(shclk_en), .line_latch(line_latch),
    .flm(flm), .m_pol(m_pol), .blink(blink)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: captures one line after each sync rise and compares with the queue head
  logic vs_prev = 1'b0;
  bit   mon_on = 1'b0;
  int   pos, since, first_sh, sh_cnt, lpos, lcnt, flm_at;
  always @(negedge clk) begin
    if (vsync_in && !vs_prev && sb_q.size() > 0) begin
      mon_on = 1'b1; pos = 0; since = 0; first_sh = -1; sh_cnt = 0;
      lpos = -1; lcnt = 0; flm_at = flm ? 0 : -1;
    end else if (mon_on) begin
      since++;
      if (flm && flm_at < 0) flm_at = since;
      if (shclk_en) begin if (first_sh < 0) first_sh = pos; sh_cnt++; end
      if (line_latch) begin if (lpos < 0) lpos = pos; lcnt++; end
      pos++;
      if (pos == sb_q[0].line_len) begin
        chk("R1/R3 display window start", first_sh, sb_q[0].first_sh);
        chk("R1/R4 shift clock dots per line", sh_cnt, sb_q[0].sh_cnt);
        chk("R2/R3 latch dot position", lpos, sb_q[0].latch_pos);
        chk("R2 latch pulses per line", lcnt, 1);
        chk("R5 FLM sample offset", flm_at, sb_q[0].flm_at);
        void'(sb_q.pop_front());
        mon_on = 1'b0;
      end
    end
    vs_prev = vsync_in;
  end

  // driver: programs a geometry, pushes the expectation, pulses sync (R9)
  task automatic line_case(input int h, input int t, input int adj, input bit alw, input bit dly);
    line_exp_t e;
    int grp, act;
    @(posedge clk); #1;
    cfg_hsize = 8'(h); cfg_scr_type = 2'(t); cfg_latch_adj = 5'(adj);
    cfg_sclk_always = alw; cfg_flm_delay = dly;
    grp = (t == 2) ? 4 : 8;
    act = (h + 1) * grp;
    e.line_len  = act + HB;
    e.first_sh  = alw ? 0 : adj;
    e.sh_cnt    = alw ? e.line_len : act;
    e.latch_pos = act + adj;
    e.flm_at    = dly ? 2 : 0;
    sb_q.push_back(e);
    @(posedge clk); #1 vsync_in = 1'b1;
    @(posedge clk); #1 vsync_in = 1'b0;
    while (sb_q.size() != 0) @(posedge clk);
  endtask

  task automatic m_case(input int p);
    logic prev;
    int changes, cnt, guard;
    @(posedge clk); #1;
    cfg_hsize = 8'd0; cfg_scr_type = 2'd0; cfg_latch_adj = 5'd0; cfg_m_period = 10'(p);
    @(negedge clk); prev = m_pol;
    changes = 0; cnt = 0; guard = 0;
    while (changes < 3 && guard < 20000) begin
      @(negedge clk); guard++;
      if (m_pol !== prev) begin
        changes++; prev = m_pol;
        if (changes == 2) cnt = 0;
      end else if (line_latch) cnt++;
    end
    chk("R6 lines between polarity reversals", cnt, p + 1);
  endtask

  task automatic blink_case(input string req, input int v, input int t, input bit slow);
    logic prev;
    int changes, cnt, guard, grp, len, lines;
    @(posedge clk); #1;
    cfg_hsize = 8'd0; cfg_scr_type = 2'(t); cfg_vsize = 9'(v); cfg_blink_slow = slow;
    cfg_latch_adj = 5'd0;
    grp = (t == 2) ? 4 : 8;
    len = grp + HB;
    lines = (t == 1) ? v + 2 : v + 1;
    @(negedge clk); prev = blink;
    changes = 0; cnt = 0; guard = 0;
    while (changes < 3 && guard < 40000) begin
      @(negedge clk); guard++; cnt++;
      if (blink !== prev) begin
        changes++; prev = blink;
        if (changes == 2) cnt = 0;
      end
    end
    chk(req, cnt, (slow ? 32 : 16) * lines * len);
  endtask

  initial begin
    int bad, idx;
    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 polarity low in reset", int'(m_pol), 0);
    chk("R11 blink low in reset", int'(blink), 0);
    chk("R11 no latch in reset", int'(line_latch), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    idx = 0;
    @(negedge clk);
    while (!line_latch && idx < 200) begin idx++; @(negedge clk); end
    chk("R11 first latch after reset at dot 8", idx, 8);

    line_case(0, 0, 0, 1'b0, 1'b0);
    line_case(3, 0, 5, 1'b0, 1'b1);
    line_case(2, 2, 0, 1'b0, 1'b0);
    line_case(1, 1, 31, 1'b0, 1'b1);
    line_case(0, 0, 3, 1'b1, 1'b0);
    line_case(79, 0, 7, 1'b0, 1'b0);
    line_case(5, 3, 2, 1'b0, 1'b1);

    m_case(0);
    m_case(3);

    blink_case("R8/R7 16-frame blink, single, 2 lines", 1, 0, 1'b0);
    blink_case("R8/R7 32-frame blink, single, 3 lines", 2, 0, 1'b1);
    blink_case("R7 dual one-port frame is vsize+2 lines", 2, 1, 1'b0);
    blink_case("R7 dual two-port frame is vsize+1 lines", 1, 2, 1'b0);

    // R10: standby silences outputs, then resumes from dot 0
    @(posedge clk); #1;
    cfg_hsize = 8'd0; cfg_scr_type = 2'd0; cfg_latch_adj = 5'd0; cfg_vsize = 9'd1;
    cfg_standby = 1'b1; cfg_sclk_always = 1'b1;
    bad = 0;
    repeat (60) begin
      @(negedge clk);
      if (shclk_en || line_latch || flm || m_pol || blink) bad++;
    end
    chk("R10 outputs low in standby", bad, 0);
    @(posedge clk); #1 vsync_in = 1'b1;
    @(negedge clk); chk("R10 FLM blocked in standby", int'(flm), 0);
    @(posedge clk); #1 begin vsync_in = 1'b0; cfg_sclk_always = 1'b0; end
    @(posedge clk); #1 cfg_standby = 1'b0;
    idx = 0;
    @(negedge clk);
    while (!line_latch && idx < 200) begin idx++; @(negedge clk); end
    chk("R10 line restarts at dot 0 after standby", idx, 8);

    line_case(4, 2, 9, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule